// File: doc/BRIEF.md
# Pointer-Addressed Flash Command Port

This block sits between a narrow register bus and a byte-wide flash controller. The bus has too few address bits to map a 21-bit flash space directly, so the port keeps its own 21-bit address pointer. Each bus access carries exactly one command, and the command is chosen by which address bit in the range 8:2 is set. Software clears the pointer, steps it one byte at a time, and reads it back. It writes or reads a single byte at the pointer, starts an erase, or resets the flash controller.

A bus access is a one-cycle strobe `sel_i` with a direction `we_i`. The port answers with a one-cycle `ack_o`. Pointer commands and control commands finish one cycle after the strobe. Byte transfers raise a request on the flash side and hold the bus acknowledge back until the flash answers. An erase is acknowledged on the bus at once. It then runs in the background with `busy_o` high, and byte transfers and new erases are refused during that time.

Top module: `flash_cmd_port`

## Requirements
- R1: After reset, `ack_o`, `fl_req_o`, `fl_rst_o` and `busy_o` are 0, `rdata_o` is 0 and the pointer is 0.
- R2: A write with address bit 2 as the selected command sets the pointer to 0. `ack_o` is high in the cycle after the strobe.
- R3: A write with address bit 7 as the selected command adds one to the pointer. The pointer wraps from its all-ones value (0x1FFFFF) to 0. `ack_o` follows one cycle after the strobe.
- R4: A read with address bit 8 as the selected command returns the pointer zero-extended on `rdata_o[23:0]`, with `ack_o` one cycle after the strobe.
- R5: A write with address bit 3 as the selected command, while not busy, raises `fl_req_o` with `fl_op_o`=2'b01, `fl_addr_o` equal to the pointer and `fl_wdata_o` equal to `wdata_i[7:0]`. `ack_o` stays low until `fl_ack_i` is sampled high, and then `ack_o` rises in the next cycle with `rdata_o`=0.
- R6: A read with address bit 4 as the selected command, while not busy, raises `fl_req_o` with `fl_op_o`=2'b00 at the pointer. The byte on `fl_rdata_i` when `fl_ack_i` is sampled appears on `rdata_o[7:0]`, with upper bits 0 and `ack_o` in the next cycle.
- R7: A write with address bit 6 as the selected command, while not busy, sets `busy_o` and holds `fl_req_o` with `fl_op_o`=2'b10 until `fl_ack_i`, which clears both. The bus `ack_o` comes one cycle after the strobe.
- R8: While `busy_o` is high, byte read, byte write and erase commands do not reach the flash. They are acknowledged one cycle after the strobe with `rdata_o`=0. Pointer commands still work.
- R9: A write with address bit 5 as the selected command pulses `fl_rst_o` for one cycle, drops `fl_req_o` and clears `busy_o`. `ack_o` follows one cycle after the strobe.
- R10: When several of address bits 8:2 are set, only the lowest-numbered one is taken as the command.
- R11: An access with no bit of 8:2 set, or whose selected command does not match `we_i` (reads for bits 4 and 8, writes for the rest), has no effect. It is acknowledged one cycle later with `rdata_o`=0.
- R12: A strobe that arrives while a byte transfer is waiting on the flash is ignored. It produces no acknowledge of its own and has no effect on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | One-cycle bus strobe for this port |
| we_i | input | 1 | 1 = write access, 0 = read access |
| cmd_addr_i | input | 7 | Bus address bits 8:2, one-hot command select |
| wdata_i | input | 8 | Bus data byte for byte writes |
| ack_o | output | 1 | One-cycle bus acknowledge |
| rdata_o | output | 24 | Bus read data, valid with `ack_o` |
| busy_o | output | 1 | Erase in progress |
| fl_req_o | output | 1 | Flash request, held until `fl_ack_i` |
| fl_op_o | output | 2 | Flash operation: 00 read, 01 write, 10 erase |
| fl_addr_o | output | 21 | Flash byte address (the pointer) |
| fl_wdata_o | output | 8 | Flash write byte |
| fl_rdata_i | input | 8 | Flash read byte, taken with `fl_ack_i` |
| fl_ack_i | input | 1 | Flash completion |
| fl_rst_o | output | 1 | One-cycle flash controller reset |

## Verification
The hardest cases to reach are the overlaps. One is a strobe that lands while a byte transfer is still waiting on the flash. Another is a byte or erase command that arrives while a background erase runs. A third is pointer wrap, which would take two million increments at full width. The bench places a strobe inside the flash wait window on purpose. It lets erases stay open across many random commands before it completes them. It drives a second copy of the block with a 5-bit pointer from the same stimulus, so wrap occurs many times in the random run.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned CMD_LSB = 2;
  localparam int unsigned N_CMD   = 7;
  localparam int unsigned CMD_MSB = CMD_LSB + N_CMD - 1;

  // order follows command bit position, lowest first
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_CLR   = 3'd1,
    CMD_WR    = 3'd2,
    CMD_RD    = 3'd3,
    CMD_FRST  = 3'd4,
    CMD_ERASE = 3'd5,
    CMD_INC   = 3'd6,
    CMD_RPTR  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_ERASE = 2'b10
  } fl_op_e;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [N_CMD-1:0] bits_i,
  input  logic             we_i,
  output cmd_e             cmd_o
);
  logic [N_CMD-1:0] grant;
  logic [N_CMD:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_CMD; i++) begin : g_prio
    assign grant[i]  = bits_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | bits_i[i];
  end

  cmd_e raw;
  always_comb begin
    raw = CMD_NONE;
    for (int i = 0; i < N_CMD; i++)
      if (grant[i]) raw = cmd_e'(i + 1);
    if (!seen[N_CMD]) raw = CMD_NONE;
  end

  // reads: byte read and pointer read; all others are writes
  always_comb begin
    cmd_o = raw;
    if ((raw == CMD_RD) || (raw == CMD_RPTR)) begin
      if (we_i) cmd_o = CMD_NONE;
    end else if (!we_i) begin
      cmd_o = CMD_NONE;
    end
  end
endmodule

// File: rtl/flash_ptr.sv
module flash_ptr #(
  parameter int unsigned PTR_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (clr_i) ptr_o <= '0;
    else if (inc_i) ptr_o <= ptr_o + 1'b1; // wraps naturally
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned PTR_W   = 21,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RDATA_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  cmd_e               cmd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [PTR_W-1:0]   ptr_i,
  input  logic [DATA_W-1:0]  fl_rdata_i,
  input  logic               fl_ack_i,
  output logic               ack_o,
  output logic [RDATA_W-1:0] rdata_o,
  output logic               byte_pend_o,
  output logic               busy_o,
  output logic               fl_req_o,
  output fl_op_e             fl_op_o,
  output logic [DATA_W-1:0]  fl_wdata_o,
  output logic               fl_rst_o
);
  logic byte_pend_q, erase_q;

  assign byte_pend_o = byte_pend_q;
  assign busy_o      = erase_q;
  assign fl_req_o    = byte_pend_q | erase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_pend_q <= 1'b0;
      erase_q     <= 1'b0;
      ack_o       <= 1'b0;
      rdata_o     <= '0;
      fl_op_o     <= OP_READ;
      fl_wdata_o  <= '0;
      fl_rst_o    <= 1'b0;
    end else begin
      ack_o    <= 1'b0;
      fl_rst_o <= 1'b0;
      // flash completion
      if (fl_ack_i && fl_req_o) begin
        if (byte_pend_q) begin
          byte_pend_q <= 1'b0;
          ack_o       <= 1'b1;
          rdata_o     <= (fl_op_o == OP_READ) ? RDATA_W'(fl_rdata_i) : '0;
        end else begin
          erase_q <= 1'b0;
        end
      end
      if (start_i) begin
        unique case (cmd_i)
          CMD_RPTR: begin
            ack_o   <= 1'b1;
            rdata_o <= RDATA_W'(ptr_i);
          end
          CMD_WR, CMD_RD: begin
            if (erase_q) begin
              ack_o   <= 1'b1;
              rdata_o <= '0;
            end else begin
              byte_pend_q <= 1'b1;
              fl_op_o     <= (cmd_i == CMD_WR) ? OP_WRITE : OP_READ;
              fl_wdata_o  <= wdata_i;
            end
          end
          CMD_ERASE: begin
            ack_o   <= 1'b1;
            rdata_o <= '0;
            if (!erase_q) begin
              erase_q <= 1'b1;
              fl_op_o <= OP_ERASE;
            end
          end
          CMD_FRST: begin
            ack_o       <= 1'b1;
            rdata_o     <= '0;
            fl_rst_o    <= 1'b1;
            erase_q     <= 1'b0;
            byte_pend_q <= 1'b0;
          end
          default: begin // CMD_NONE, CMD_CLR, CMD_INC
            ack_o   <= 1'b1;
            rdata_o <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_port.sv
module flash_cmd_port
  import flash_cmd_pkg::*;
#(
  parameter int unsigned PTR_W   = 21,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RDATA_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [CMD_MSB:CMD_LSB] cmd_addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ack_o,
  output logic [RDATA_W-1:0] rdata_o,
  output logic               busy_o,
  output logic               fl_req_o,
  output logic [1:0]         fl_op_o,
  output logic [PTR_W-1:0]   fl_addr_o,
  output logic [DATA_W-1:0]  fl_wdata_o,
  input  logic [DATA_W-1:0]  fl_rdata_i,
  input  logic               fl_ack_i,
  output logic               fl_rst_o
);
  cmd_e   cmd;
  fl_op_e op;
  logic   byte_pend, start;
  logic [PTR_W-1:0] ptr;

  flash_cmd_decode u_dec (
    .bits_i (cmd_addr_i),
    .we_i   (we_i),
    .cmd_o  (cmd)
  );

  // strobes during an outstanding byte transfer are dropped
  assign start = sel_i & ~byte_pend;

  flash_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start && (cmd == CMD_CLR)),
    .inc_i  (start && (cmd == CMD_INC)),
    .ptr_o  (ptr)
  );

  flash_seq #(.PTR_W(PTR_W), .DATA_W(DATA_W), .RDATA_W(RDATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmd_i       (cmd),
    .wdata_i     (wdata_i),
    .ptr_i       (ptr),
    .fl_rdata_i  (fl_rdata_i),
    .fl_ack_i    (fl_ack_i),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .byte_pend_o (byte_pend),
    .busy_o      (busy_o),
    .fl_req_o    (fl_req_o),
    .fl_op_o     (op),
    .fl_wdata_o  (fl_wdata_o),
    .fl_rst_o    (fl_rst_o)
  );

  assign fl_op_o   = op;
  assign fl_addr_o = ptr;
endmodule

// File: rtl/flash_cmd_port_chk.sv
module flash_cmd_port_chk
  import flash_cmd_pkg::*;
#(
  parameter int unsigned PTR_W  = 21,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              ack_o,
  input logic              busy_o,
  input logic              fl_req_o,
  input logic [1:0]        fl_op_o,
  input logic [PTR_W-1:0]  fl_addr_o,
  input logic [DATA_W-1:0] fl_wdata_o,
  input logic              fl_ack_i,
  input logic              fl_rst_o
);
  // R5: bus ack held off while a byte request waits
  p_ack_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o != 2'b10 && !fl_ack_i) |=> !ack_o);

  // R12: byte request fields frozen while waiting
  p_byte_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o != 2'b10 && !fl_ack_i) |=>
      (fl_req_o && $stable(fl_addr_o) && $stable(fl_wdata_o) && $stable(fl_op_o)));

  // R7: erase request held until acknowledged
  p_erase_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o == 2'b10 && !fl_ack_i && !sel_i) |=> (fl_req_o && busy_o));

  // R8: busy always corresponds to an erase request
  p_busy_erase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (fl_req_o && fl_op_o == 2'b10));

  // R9: flash reset pulse leaves no request behind
  p_rst_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_rst_o |-> (!fl_req_o && !busy_o));

  // R11: every ack has a strobe or flash completion behind it
  p_ack_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(sel_i) || $past(fl_ack_i)));
endmodule

bind flash_cmd_port flash_cmd_port_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/flash_cmd_port_tb_top.sv
module flash_cmd_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        sel = 0, we = 0, fl_ack = 0;
  logic [8:0]  addr = '0;
  logic [7:0]  wdata = '0, fl_rdata = '0;
  logic        ack, busy, fl_req, fl_rst;
  logic [1:0]  fl_op;
  logic [20:0] fl_addr;
  logic [7:0]  fl_wdata;
  logic [23:0] rdata;
  // narrow copy for wrap coverage
  logic        ack_w, busy_w, fl_req_w, fl_rst_w;
  logic [1:0]  fl_op_w;
  logic [4:0]  fl_addr_w;
  logic [7:0]  fl_wdata_w;
  logic [23:0] rdata_w;

  flash_cmd_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .cmd_addr_i(addr[8:2]),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .busy_o(busy), .fl_req_o(fl_req),
    .fl_op_o(fl_op), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata),
    .fl_ack_i(fl_ack), .fl_rst_o(fl_rst));

  flash_cmd_port #(.PTR_W(5)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .cmd_addr_i(addr[8:2]),
    .wdata_i(wdata), .ack_o(ack_w), .rdata_o(rdata_w), .busy_o(busy_w), .fl_req_o(fl_req_w),
    .fl_op_o(fl_op_w), .fl_addr_o(fl_addr_w), .fl_wdata_o(fl_wdata_w), .fl_rdata_i(fl_rdata),
    .fl_ack_i(fl_ack), .fl_rst_o(fl_rst_w));

  int checks = 0, errors = 0;
  int unsigned m_ptr = 0;
  bit m_busy = 0, done = 0;

  localparam int K_NONE = 0, K_CLR = 1, K_WR = 2, K_RD = 3, K_FRST = 4,
                 K_ERASE = 5, K_INC = 6, K_RPTR = 7;

  task automatic chk(bit ok, string req, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_cmd(bit w, logic [8:0] a);
    int k = K_NONE;
    for (int i = 8; i >= 2; i--) if (a[i]) k = i - 1;
    if (k == K_RD || k == K_RPTR) begin if (w) k = K_NONE; end
    else if (!w) k = K_NONE;
    return k;
  endfunction

  task automatic run_op(bit w, logic [8:0] a, logic [7:0] d, int lat);
    int k = model_cmd(w, a);
    logic [7:0] b;
    @(negedge clk); sel = 1; we = w; addr = a; wdata = d;
    @(negedge clk); sel = 0;
    if ((k == K_WR || k == K_RD) && !m_busy) begin
      chk(ack == 0, "R5 ack held", ack, 0);
      chk(fl_req == 1 && fl_addr == 21'(m_ptr), "R5/R6 request at pointer", fl_addr, m_ptr & 32'h1FFFFF);
      chk(fl_op == (k == K_WR ? 2'b01 : 2'b00), "R5/R6 op", fl_op, k == K_WR ? 1 : 0);
      if (k == K_WR) chk(fl_wdata == d, "R5 wdata", fl_wdata, d);
      for (int i = 0; i < lat; i++) @(negedge clk);
      b = 8'($urandom);
      fl_ack = 1; fl_rdata = b;
      @(negedge clk); fl_ack = 0;
      chk(ack == 1, "R5/R6 ack after flash", ack, 1);
      chk(rdata == (k == K_RD ? {16'h0, b} : 24'h0), "R6 byte data", rdata, k == K_RD ? b : 0);
      chk(fl_req == 0, "R5 request dropped", fl_req, 0);
    end else begin
      chk(ack == 1, "R2/R3/R8/R11 one-cycle ack", ack, 1);
      case (k)
        K_CLR: m_ptr = 0;
        K_INC: m_ptr = m_ptr + 1;
        K_RPTR: begin
          chk(rdata == 24'(m_ptr & 32'h1FFFFF), "R4 pointer read", rdata, m_ptr & 32'h1FFFFF);
          chk(rdata_w == 24'(m_ptr & 32'h1F), "R3 wrap narrow", rdata_w, m_ptr & 32'h1F);
        end
        K_ERASE: begin
          m_busy = 1;
          chk(busy == 1 && fl_req == 1 && fl_op == 2'b10, "R7 erase started", {busy, fl_req, fl_op}, 4'hE);
        end
        K_FRST: begin
          m_busy = 0;
          chk(fl_rst == 1 && fl_req == 0 && busy == 0, "R9 flash reset", {fl_rst, fl_req, busy}, 4);
        end
        default: ;
      endcase
      if (k != K_RPTR) chk(rdata == 0, "R8/R11 zero read data", rdata, 0);
    end
  endtask

  task automatic finish_erase();
    @(negedge clk);
    chk(fl_req == 1 && fl_op == 2'b10, "R7 erase held", {fl_req, fl_op}, 6);
    fl_ack = 1;
    @(negedge clk); fl_ack = 0;
    chk(busy == 0 && fl_req == 0 && ack == 0, "R7 erase done", {busy, fl_req, ack}, 0);
    m_busy = 0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(ack == 0 && fl_req == 0 && fl_rst == 0 && busy == 0 && rdata == 0, "R1 reset state",
        {ack, fl_req, fl_rst, busy}, 0);
    rst_n = 1;
    run_op(0, 9'h100, 0, 0);                          // R4 pointer 0
    for (int i = 0; i < 3; i++) run_op(1, 9'h080, 0, 0); // R3
    run_op(0, 9'h100, 0, 0);
    run_op(1, 9'h004, 0, 0);                          // R2
    run_op(0, 9'h100, 0, 0);
    run_op(1, 9'h080, 0, 0);
    run_op(1, 9'h008, 8'hA5, 2);                      // R5
    run_op(0, 9'h010, 0, 3);                          // R6
    run_op(1, 9'h040, 0, 0);                          // R7
    run_op(1, 9'h008, 8'h11, 0);                      // R8 write refused
    run_op(0, 9'h010, 0, 0);                          // R8 read refused
    run_op(1, 9'h040, 0, 0);                          // R8 erase refused
    run_op(1, 9'h080, 0, 0);                          // pointer still works
    run_op(0, 9'h100, 0, 0);
    finish_erase();
    run_op(1, 9'h040, 0, 0);
    run_op(1, 9'h020, 0, 0);                          // R9 abort erase
    run_op(1, 9'h084, 0, 0);                          // R10 clear wins over inc
    run_op(0, 9'h100, 0, 0);
    run_op(1, 9'h180, 0, 0);                          // R10 inc wins
    run_op(0, 9'h110, 0, 1);                          // R10 byte read wins
    run_op(0, 9'h004, 0, 0);                          // R11 wrong direction
    run_op(1, 9'h100, 0, 0);                          // R11 wrong direction
    run_op(1, 9'h003, 0, 0);                          // R11 no command bit
    run_op(0, 9'h100, 0, 0);
    // R12: strobe during outstanding byte write
    @(negedge clk); sel = 1; we = 1; addr = 9'h008; wdata = 8'h3C;
    @(negedge clk); sel = 1; we = 1; addr = 9'h004;
    @(negedge clk); sel = 0;
    chk(ack == 0 && fl_req == 1, "R12 strobe ignored", {ack, fl_req}, 1);
    fl_ack = 1;
    @(negedge clk); fl_ack = 0;
    chk(ack == 1, "R12 single ack", ack, 1);
    @(negedge clk);
    chk(ack == 0, "R12 no extra ack", ack, 0);
    run_op(0, 9'h100, 0, 0);                          // pointer unchanged
    for (int i = 0; i < 40; i++) run_op(1, 9'h080, 0, 0); // R3 wrap narrow copy
    run_op(0, 9'h100, 0, 0);
    for (int n = 0; n < 500; n++) begin
      int r = int'($urandom % 10);
      logic [8:0] a;
      if (m_busy && ($urandom % 5 == 0)) finish_erase();
      if (r < 7) a = 9'(1 << (2 + $urandom % 7));
      else if (r < 9) a = 9'($urandom) & 9'h1FC;
      else a = 9'($urandom % 4);
      run_op(1'($urandom), a, 8'($urandom), int'($urandom % 4));
    end
    if (m_busy) finish_erase();
    run_op(0, 9'h100, 0, 0);
    finish();
  end
endmodule